// File: doc/BRIEF.md
# Decimal Limit Go/No-Go Checker

This block grades a decimal measurement against two limits. The measurement and both limits are given as packed BCD, four digits by default. The most significant digit sits in the top nibble. When a measurement is accepted, the block makes three comparisons:

- whether the measurement lies strictly above the upper limit;
- whether it lies strictly below the lower limit;
- whether either limit holds a digit that is not a decimal digit.

The results are held in registers until the next accepted measurement. From the held flags, a three-lamp indicator lights exactly one of red, yellow or green.

Measurements arrive on a valid/ready stream. There is no back-pressure: `meas_ready` is high in every cycle outside reset, so a measurement is taken on each clock edge where `meas_valid` is high. The limit inputs are plain static settings, sampled on that same edge. The outputs are plain registered status levels with no handshake.

Top module: `bcd_limit_grader`

## Requirements
- R1: On an accepted measurement, `over_limit` becomes 1 exactly when the measurement is strictly greater than `upper_lim`. Equality gives 0. Digits are ranked most significant first, and the first unequal nibble (compared as an unsigned 4-bit value) decides the result.
- R2: On an accepted measurement, `under_limit` becomes 1 exactly when the measurement is strictly less than `lower_lim`. It uses the same most-significant-first nibble ranking, and equality gives 0.
- R3: `lamp_red` is 1 exactly when `over_limit` is 1. This gives red priority when both violations hold, for example when the lower limit is set above the upper limit.
- R4: `lamp_yellow` is 1 exactly when `under_limit` is 1 and `over_limit` is 0.
- R5: `lamp_green` is 1 exactly when the block has taken at least one measurement since reset and neither violation flag is 1. After the first accepted measurement, exactly one lamp is lit.
- R6: While `rst_n` is low, and in the first cycle after it rises, all status outputs and all lamps are 0. `meas_ready` is 0 during reset and 1 in every cycle after it.
- R7: In a cycle without an accepted measurement, every status output and lamp keeps its value, whatever `meas_bcd`, `upper_lim` or `lower_lim` do.
- R8: On an accepted measurement, `limit_err` becomes 1 exactly when any nibble of `upper_lim` or `lower_lim` has a value from 10 to 15. The comparisons of R1 and R2 are still made on the raw nibble values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | Measurement stream valid |
| meas_ready | output | 1 | Measurement stream ready, high outside reset |
| meas_bcd | input | 4*DIGITS | Measurement, packed BCD, most significant digit highest |
| upper_lim | input | 4*DIGITS | Upper limit setting, packed BCD |
| lower_lim | input | 4*DIGITS | Lower limit setting, packed BCD |
| over_limit | output | 1 | Held flag: last measurement above upper limit |
| under_limit | output | 1 | Held flag: last measurement below lower limit |
| limit_err | output | 1 | Held flag: a limit digit was not decimal |
| lamp_red | output | 1 | Red indicator |
| lamp_yellow | output | 1 | Yellow indicator |
| lamp_green | output | 1 | Green indicator |

## Verification
The bench builds the block with `DIGITS = 2`, so the measurement range is only 0 to 99. That small range lets every measurement value be swept against a grid of limit pairs. The grid includes equal limits, limits at 0 and 99, and inverted pairs where both violations hold at once. The same two-digit width lets the bench also sweep all measurements against limits containing the codes A to F. Expected flags come from comparing the packed vectors as plain unsigned numbers.

// File: rtl/bcd_grade_pkg.sv
package bcd_grade_pkg;
  localparam int unsigned NIBBLE_W = 4;
  localparam logic [NIBBLE_W-1:0] MAX_DEC_DIGIT = 4'd9;

  typedef struct packed {
    logic gt;
    logic lt;
  } order_t;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } lamps_t;

  localparam order_t ORDER_EQ = '{gt: 1'b0, lt: 1'b0};
  localparam lamps_t LAMPS_DARK = '{red: 1'b0, yellow: 1'b0, green: 1'b0};
endpackage

// File: rtl/bcd_digit_order.sv
module bcd_digit_order
  import bcd_grade_pkg::*;
(
  input  logic [NIBBLE_W-1:0] lhs,
  input  logic [NIBBLE_W-1:0] rhs,
  output order_t              ord
);
  always_comb begin
    ord.gt = (lhs > rhs);
    ord.lt = (lhs < rhs);
  end
endmodule

// File: rtl/bcd_magnitude_cmp.sv
module bcd_magnitude_cmp
  import bcd_grade_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned BUS_W = DIGITS * NIBBLE_W
) (
  input  logic [BUS_W-1:0] lhs,
  input  logic [BUS_W-1:0] rhs,
  output order_t           ord
);
  order_t digit_ord [DIGITS];
  // chain[i] is the ordering decided by digits i-1 down to 0
  order_t chain [DIGITS+1];

  assign chain[0] = ORDER_EQ;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    bcd_digit_order u_dig (
      .lhs (lhs[i*NIBBLE_W +: NIBBLE_W]),
      .rhs (rhs[i*NIBBLE_W +: NIBBLE_W]),
      .ord (digit_ord[i])
    );
    // a more significant unequal digit overrides everything below it
    assign chain[i+1] = (digit_ord[i].gt || digit_ord[i].lt) ? digit_ord[i] : chain[i];
  end

  assign ord = chain[DIGITS];
endmodule

// File: rtl/bcd_setting_check.sv
module bcd_setting_check
  import bcd_grade_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned BUS_W = DIGITS * NIBBLE_W
) (
  input  logic [BUS_W-1:0] setting,
  output logic             bad
);
  logic [DIGITS-1:0] bad_digit;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assign bad_digit[i] = (setting[i*NIBBLE_W +: NIBBLE_W] > MAX_DEC_DIGIT);
  end

  assign bad = |bad_digit;
endmodule

// File: rtl/grade_lamp_select.sv
module grade_lamp_select
  import bcd_grade_pkg::*;
(
  input  logic   seen,
  input  logic   over,
  input  logic   under,
  output lamps_t lamps
);
  always_comb begin
    lamps = LAMPS_DARK;
    if (seen) begin
      if (over)       lamps.red    = 1'b1;
      else if (under) lamps.yellow = 1'b1;
      else            lamps.green  = 1'b1;
    end
  end
endmodule

// File: rtl/bcd_limit_grader.sv
module bcd_limit_grader
  import bcd_grade_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned BUS_W = DIGITS * NIBBLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_valid,
  output logic             meas_ready,
  input  logic [BUS_W-1:0] meas_bcd,
  input  logic [BUS_W-1:0] upper_lim,
  input  logic [BUS_W-1:0] lower_lim,
  output logic             over_limit,
  output logic             under_limit,
  output logic             limit_err,
  output logic             lamp_red,
  output logic             lamp_yellow,
  output logic             lamp_green
);
  order_t vs_upper;
  order_t vs_lower;
  logic   upper_bad;
  logic   lower_bad;
  logic   accept;
  logic   seen_q;
  logic   over_q;
  logic   under_q;
  logic   err_q;
  logic   ready_q;
  lamps_t lamps_d;
  lamps_t lamps_q;

  bcd_magnitude_cmp #(.DIGITS(DIGITS)) u_cmp_upper (
    .lhs (meas_bcd),
    .rhs (upper_lim),
    .ord (vs_upper)
  );

  bcd_magnitude_cmp #(.DIGITS(DIGITS)) u_cmp_lower (
    .lhs (meas_bcd),
    .rhs (lower_lim),
    .ord (vs_lower)
  );

  bcd_setting_check #(.DIGITS(DIGITS)) u_chk_upper (
    .setting (upper_lim),
    .bad     (upper_bad)
  );

  bcd_setting_check #(.DIGITS(DIGITS)) u_chk_lower (
    .setting (lower_lim),
    .bad     (lower_bad)
  );

  assign accept = meas_valid && ready_q;

  grade_lamp_select u_lamps (
    .seen  (seen_q),
    .over  (over_q),
    .under (under_q),
    .lamps (lamps_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      seen_q  <= 1'b0;
      over_q  <= 1'b0;
      under_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (accept) begin
        seen_q  <= 1'b1;
        over_q  <= vs_upper.gt;
        under_q <= vs_lower.lt;
        err_q   <= upper_bad || lower_bad;
      end
    end
  end

  // lamp selection is combinational over held flags, so it updates with them
  assign lamps_q     = lamps_d;
  assign meas_ready  = ready_q;
  assign over_limit  = over_q;
  assign under_limit = under_q;
  assign limit_err   = err_q;
  assign lamp_red    = lamps_q.red;
  assign lamp_yellow = lamps_q.yellow;
  assign lamp_green  = lamps_q.green;
endmodule

// File: rtl/bcd_limit_grader_props.sv
module bcd_limit_grader_props #(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned BUS_W = DIGITS * 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_valid,
  input logic             meas_ready,
  input logic [BUS_W-1:0] meas_bcd,
  input logic [BUS_W-1:0] upper_lim,
  input logic [BUS_W-1:0] lower_lim,
  input logic             over_limit,
  input logic             under_limit,
  input logic             limit_err,
  input logic             lamp_red,
  input logic             lamp_yellow,
  input logic             lamp_green
);
  logic took;
  assign took = meas_valid && meas_ready;

  assert_over_strict_R1: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (over_limit == ($past(meas_bcd) > $past(upper_lim))));

  assert_under_strict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (under_limit == ($past(meas_bcd) < $past(lower_lim))));

  assert_red_follows_over_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_red == over_limit);

  assert_yellow_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_yellow |-> (under_limit && !over_limit));

  assert_single_lamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lamp_red, lamp_yellow, lamp_green}));

  assert_green_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_green |-> (!over_limit && !under_limit));

  assert_lit_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> ($countones({lamp_red, lamp_yellow, lamp_green}) == 1));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable({over_limit, under_limit, limit_err, lamp_red, lamp_yellow, lamp_green}));
endmodule

bind bcd_limit_grader bcd_limit_grader_props #(.DIGITS(DIGITS)) u_props (
  .clk         (clk),
  .rst_n       (rst_n),
  .meas_valid  (meas_valid),
  .meas_ready  (meas_ready),
  .meas_bcd    (meas_bcd),
  .upper_lim   (upper_lim),
  .lower_lim   (lower_lim),
  .over_limit  (over_limit),
  .under_limit (under_limit),
  .limit_err   (limit_err),
  .lamp_red    (lamp_red),
  .lamp_yellow (lamp_yellow),
  .lamp_green  (lamp_green)
);

// File: tb/bcd_limit_grader_bench.sv
module bcd_limit_grader_bench;
  localparam int unsigned DIGITS = 2;
  localparam int unsigned BUS_W = DIGITS * 4;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             meas_valid = 1'b0;
  logic             meas_ready;
  logic [BUS_W-1:0] meas_bcd = '0;
  logic [BUS_W-1:0] upper_lim = '0;
  logic [BUS_W-1:0] lower_lim = '0;
  logic             over_limit, under_limit, limit_err;
  logic             lamp_red, lamp_yellow, lamp_green;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_limit_grader #(.DIGITS(DIGITS)) u_bcd_limit_grader (
    .clk, .rst_n, .meas_valid, .meas_ready, .meas_bcd, .upper_lim, .lower_lim,
    .over_limit, .under_limit, .limit_err, .lamp_red, .lamp_yellow, .lamp_green
  );

  function automatic logic [BUS_W-1:0] to_bcd(input int v);
    logic [BUS_W-1:0] r = '0;
    int x = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic nib_bad(input logic [BUS_W-1:0] s);
    logic b = 1'b0;
    for (int i = 0; i < DIGITS; i++) if (s[i*4 +: 4] > 4'd9) b = 1'b1;
    return b;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b (meas %h up %h lo %h)",
               req, act, exp, meas_bcd, upper_lim, lower_lim);
    end
  endtask

  // expected outputs from last taken inputs
  task automatic check_all(input logic [BUS_W-1:0] m, input logic [BUS_W-1:0] u,
                           input logic [BUS_W-1:0] l);
    logic eo, eu, ee;
    eo = (m > u);
    eu = (m < l);
    ee = nib_bad(u) || nib_bad(l);
    check("R1 over_limit", over_limit, eo);
    check("R2 under_limit", under_limit, eu);
    check("R3 lamp_red", lamp_red, eo);
    check("R4 lamp_yellow", lamp_yellow, eu && !eo);
    check("R5 lamp_green", lamp_green, !eo && !eu);
    check("R8 limit_err", limit_err, ee);
  endtask

  task automatic take(input logic [BUS_W-1:0] m, input logic [BUS_W-1:0] u,
                      input logic [BUS_W-1:0] l);
    @(negedge clk);
    meas_bcd = m; upper_lim = u; lower_lim = l; meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    check_all(m, u, l);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ups[5] = '{0, 9, 37, 50, 99};
    int los[4] = '{0, 20, 37, 99};
    logic [BUS_W-1:0] lm, lu, ll;
    // R6: reset state
    repeat (3) @(negedge clk);
    check("R6 ready in reset", meas_ready, 1'b0);
    check("R6 red in reset", lamp_red, 1'b0);
    check("R6 green in reset", lamp_green, 1'b0);
    check("R6 over in reset", over_limit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 ready after reset", meas_ready, 1'b1);
    check("R6 lamps dark before first take", lamp_red | lamp_yellow | lamp_green, 1'b0);
    check("R6 err after reset", limit_err, 1'b0);

    // R1..R5 sweep, including inverted limit pairs
    foreach (ups[a]) foreach (los[b])
      for (int m = 0; m < 100; m++)
        take(to_bcd(m), to_bcd(ups[a]), to_bcd(los[b]));

    // R8: non-decimal limit nibbles, raw ranking still applied
    for (int m = 0; m < 100; m++) take(to_bcd(m), 8'hA5, 8'h3F);
    for (int m = 0; m < 100; m++) take(to_bcd(m), 8'h99, 8'h0C);
    take(to_bcd(42), to_bcd(50), to_bcd(10));

    // R7: inputs move without valid, outputs hold
    lm = to_bcd(70); lu = to_bcd(60); ll = to_bcd(10);
    take(lm, lu, ll);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      meas_bcd = to_bcd(k); upper_lim = 8'hFF; lower_lim = to_bcd(90 + k);
      @(negedge clk);
      check("R7 hold over", over_limit, 1'b1);
      check("R7 hold red", lamp_red, 1'b1);
      check("R7 hold err", limit_err, 1'b0);
      check("R7 hold green", lamp_green, 1'b0);
    end
    finish_run();
  end
endmodule